// File: doc/BRIEF.md
# CAN Mailbox Transmit Cancel Controller

This block keeps, for each of 32 CAN mailboxes, a transmit-pending flag, a cancel-request flag and an in-flight flag. It settles every cancel request against what the protocol engine is doing with that mailbox. A mailbox that is waiting and not yet on the bus is withdrawn at once and reports an abort. A mailbox already on the bus runs to completion. Its outcome then picks the report: a good frame gives a transmit acknowledge, and a lost arbitration or a bus error gives an abort acknowledge with no retry.

The CPU reaches the flags through four 16-bit registers, selected by a 2-bit address. Address 0 holds pending bits for mailboxes 15..0 and address 1 holds those for mailboxes 31..16. Addresses 2 and 3 hold the cancel bits in the same layout. Bit k of a register stands for mailbox 16*index+k. Writes only ever set bits; a written 0 changes nothing. Readback is combinational from the flag registers. The protocol engine supplies per-mailbox start, success and failure pulses. The block answers with one-cycle registered acknowledge set pulses. Clearing the acknowledge flags is left to a separate status block.

Top module: `can_txcancel_ctrl`

## Requirements
- R1: After reset every pending, cancel and in-flight flag is 0, all four registers read 0 and both acknowledge outputs are 0.
- R2: Writing 1 to bit k of register 0 or 1 sets the pending flag of the mailbox it maps to, but only if that mailbox's tx_cfg bit is 1. Written zeros, and mailboxes not configured for transmit, are left unchanged.
- R3: A 1 written to a cancel bit (register 2 or 3) is ignored unless the mailbox is pending and configured for transmit. Mailbox 0 has no cancel bit: bit 0 of register 2 always reads 0.
- R4: A valid cancel on a pending mailbox that is not in flight takes effect at the clock edge of the write. After that edge the pending bit is 0, the cancel bit is 0 and aback_set pulses for that mailbox.
- R5: A valid cancel on an in-flight mailbox sets its cancel bit and leaves pending at 1. A start pulse in the same cycle as the cancel write counts as in flight.
- R6: A success on an in-flight mailbox clears its pending, cancel and in-flight flags and pulses txack_set, whether or not a cancel was requested. It never pulses aback_set.
- R7: A failure on an in-flight mailbox with a cancel request clears pending and cancel and pulses aback_set. A failure in the same cycle as a valid cancel write counts the same way.
- R8: A failure on an in-flight mailbox without a cancel request clears only the in-flight flag. Pending stays 1, no acknowledge pulses, and the mailbox may be started again.
- R9: aback_set and txack_set are one-cycle registered pulses. They are never both 1 for one mailbox, and never high on two consecutive cycles for one mailbox.
- R10: A start pulse has effect only on a pending mailbox that is not in flight. Success and failure pulses for a mailbox not in flight are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select: 0/1 pending low/high, 2/3 cancel low/high |
| cpu_wdata | input | 16 | Write data, 1 bits set flags |
| cpu_rdata | output | 16 | Readback of the selected register |
| tx_cfg | input | 32 | Mailbox configured for transmit |
| pe_start | input | 32 | Protocol engine starts transmitting the mailbox |
| pe_done_ok | input | 32 | Transmission ended successfully |
| pe_done_fail | input | 32 | Transmission ended by arbitration loss or bus error |
| aback_set | output | 32 | Abort acknowledge set pulse |
| txack_set | output | 32 | Transmit acknowledge set pulse |

## Verification
The assertions assume that the protocol engine never raises success and failure for one mailbox in the same cycle. They also assume tx_cfg only changes while a mailbox holds no pending work. The random stimulus draws completion pulses mostly from the mailboxes the bench model believes are in flight, and keeps success and failure disjoint. It also injects a small share of stray successes on idle mailboxes and starts on arbitrary mailboxes, to show they are ignored. The tx_cfg pattern is fixed for the whole run, with two receive-only mailboxes.

// File: rtl/txc_pkg.sv
`timescale 1ns/1ps
package txc_pkg;
  // Register kind, selected by the top address bit
  typedef enum logic {
    REG_PEND = 1'b0,
    REG_CANC = 1'b1
  } txc_kind_e;

  // Flags kept per mailbox
  typedef struct packed {
    logic pend;
    logic canc;
    logic busy;
  } txc_mb_state_t;
endpackage

// File: rtl/txc_regif.sv
`timescale 1ns/1ps
module txc_regif
  import txc_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int REG_W  = 16,
  localparam int NUM_REG = NUM_MB / REG_W,
  localparam int IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  input  logic [NUM_MB-1:0] pend_vec,
  input  logic [NUM_MB-1:0] canc_vec,
  output logic [NUM_MB-1:0] wr_pend_vec,
  output logic [NUM_MB-1:0] wr_canc_vec,
  output logic [REG_W-1:0]  cpu_rdata
);
  txc_kind_e        kind;
  logic [IDX_W-1:0] idx;

  assign kind = txc_kind_e'(cpu_addr[ADDR_W-1]);
  assign idx  = cpu_addr[IDX_W-1:0];

  // Per-mailbox write strobes: bit m%REG_W of register m/REG_W
  for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
    localparam int RI = m / REG_W;
    localparam int BI = m % REG_W;
    logic hit;
    assign hit = cpu_wr && (idx == IDX_W'(RI)) && cpu_wdata[BI];
    assign wr_pend_vec[m] = hit && (kind == REG_PEND);
    assign wr_canc_vec[m] = hit && (kind == REG_CANC);
  end

  // Readback
  always_comb begin
    logic [NUM_MB-1:0] src;
    src       = (kind == REG_CANC) ? canc_vec : pend_vec;
    cpu_rdata = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (idx == IDX_W'(r)) cpu_rdata = src[r*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/txc_mb_slice.sv
`timescale 1ns/1ps
module txc_mb_slice
  import txc_pkg::*;
#(
  parameter bit CAN_CANCEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_cfg,
  input  logic wr_pend,
  input  logic wr_canc,
  input  logic tx_start,
  input  logic done_ok,
  input  logic done_fail,
  output logic pend_o,
  output logic canc_o,
  output logic busy_o,
  output logic aback_o,
  output logic txack_o
);
  txc_mb_state_t st_q, st_d;
  logic ab_d, tx_d;
  logic cancel_hit, start_hit, ok_hit, fail_hit;

  if (CAN_CANCEL) begin : g_canc
    assign cancel_hit = wr_canc & tx_cfg & st_q.pend;
  end else begin : g_nocanc
    assign cancel_hit = wr_canc & 1'b0;
  end

  assign ok_hit    = done_ok & st_q.busy;
  assign fail_hit  = done_fail & st_q.busy & ~done_ok;
  assign start_hit = tx_start & st_q.pend & ~st_q.busy;

  always_comb begin
    st_d = st_q;
    ab_d = 1'b0;
    tx_d = 1'b0;
    if (ok_hit) begin
      // Success wins over any cancel
      st_d = '0;
      tx_d = 1'b1;
    end else if (fail_hit) begin
      st_d.busy = 1'b0;
      if (st_q.canc | cancel_hit) begin
        st_d.pend = 1'b0;
        st_d.canc = 1'b0;
        ab_d      = 1'b1;
      end
    end else begin
      if (start_hit) st_d.busy = 1'b1;
      if (cancel_hit) begin
        if (st_q.busy | start_hit) begin
          st_d.canc = 1'b1;
        end else begin
          st_d.pend = 1'b0;
          ab_d      = 1'b1;
        end
      end else if (wr_pend & tx_cfg) begin
        st_d.pend = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      aback_o <= 1'b0;
      txack_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      aback_o <= ab_d;
      txack_o <= tx_d;
    end
  end

  assign pend_o = st_q.pend;
  assign canc_o = st_q.canc;
  assign busy_o = st_q.busy;
endmodule

// File: rtl/can_txcancel_ctrl.sv
`timescale 1ns/1ps
module can_txcancel_ctrl
  import txc_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int REG_W  = 16,
  localparam int NUM_REG = NUM_MB / REG_W,
  localparam int IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic [NUM_MB-1:0] tx_cfg,
  input  logic [NUM_MB-1:0] pe_start,
  input  logic [NUM_MB-1:0] pe_done_ok,
  input  logic [NUM_MB-1:0] pe_done_fail,
  output logic [NUM_MB-1:0] aback_set,
  output logic [NUM_MB-1:0] txack_set
);
  logic [NUM_MB-1:0] pend_q, canc_q, busy_q;
  logic [NUM_MB-1:0] wr_pend_vec, wr_canc_vec;

  txc_regif #(
    .NUM_MB(NUM_MB),
    .REG_W (REG_W)
  ) u_regif (
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .pend_vec   (pend_q),
    .canc_vec   (canc_q),
    .wr_pend_vec(wr_pend_vec),
    .wr_canc_vec(wr_canc_vec),
    .cpu_rdata  (cpu_rdata)
  );

  // Mailbox 0 is built without a cancel path
  for (genvar m = 0; m < NUM_MB; m++) begin : g_slice
    txc_mb_slice #(
      .CAN_CANCEL(m != 0)
    ) u_mb (
      .clk      (clk),
      .rst      (rst),
      .tx_cfg   (tx_cfg[m]),
      .wr_pend  (wr_pend_vec[m]),
      .wr_canc  (wr_canc_vec[m]),
      .tx_start (pe_start[m]),
      .done_ok  (pe_done_ok[m]),
      .done_fail(pe_done_fail[m]),
      .pend_o   (pend_q[m]),
      .canc_o   (canc_q[m]),
      .busy_o   (busy_q[m]),
      .aback_o  (aback_set[m]),
      .txack_o  (txack_set[m])
    );
  end
endmodule

// File: rtl/txc_checker.sv
`timescale 1ns/1ps
module txc_checker #(
  parameter int NUM_MB = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic [NUM_MB-1:0] pe_done_ok,
  input logic [NUM_MB-1:0] pe_done_fail,
  input logic [NUM_MB-1:0] pend,
  input logic [NUM_MB-1:0] canc,
  input logic [NUM_MB-1:0] busy,
  input logic [NUM_MB-1:0] aback_set,
  input logic [NUM_MB-1:0] txack_set
);
  a_r9_ack_exclusive: assert property (@(posedge clk) disable iff (rst)
    (aback_set & txack_set) == '0);

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    ((aback_set & $past(aback_set)) | (txack_set & $past(txack_set))) == '0);

  a_r5_cancel_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (canc & ~pend) == '0);

  a_r3_mb0_no_cancel: assert property (@(posedge clk) disable iff (rst)
    canc[0] == 1'b0);

  a_r6_txack_after_ok: assert property (@(posedge clk) disable iff (rst)
    (txack_set & ~$past(pe_done_ok)) == '0);

  a_r4_aback_source: assert property (@(posedge clk) disable iff (rst)
    (aback_set != '0) |-> ($past(cpu_wr) || ($past(pe_done_fail) != '0)));

  a_r7_ack_clears_pending: assert property (@(posedge clk) disable iff (rst)
    ((aback_set | txack_set) & pend) == '0);

  a_r10_busy_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (busy & ~pend) == '0);
endmodule

bind can_txcancel_ctrl txc_checker #(.NUM_MB(NUM_MB)) u_txc_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_wr      (cpu_wr),
  .pe_done_ok  (pe_done_ok),
  .pe_done_fail(pe_done_fail),
  .pend        (pend_q),
  .canc        (canc_q),
  .busy        (busy_q),
  .aback_set   (aback_set),
  .txack_set   (txack_set)
);

// File: tb/tb_can_txcancel_ctrl.sv
`timescale 1ns/1ps
module tb_can_txcancel_ctrl;
  localparam int NMB = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_wr;
  logic [1:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic [31:0] tx_cfg, pe_start, pe_done_ok, pe_done_fail;
  logic [31:0] aback_set, txack_set;

  logic [31:0] m_pend, m_canc, m_busy, e_ab, e_tx;
  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  can_txcancel_ctrl dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_cfg(tx_cfg),
    .pe_start(pe_start), .pe_done_ok(pe_done_ok), .pe_done_fail(pe_done_fail),
    .aback_set(aback_set), .txack_set(txack_set)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [15:0] exp_reg(input int r);
    case (r)
      0: return m_pend[15:0];
      1: return m_pend[31:16];
      2: return m_canc[15:0];
      default: return m_canc[31:16];
    endcase
  endfunction

  // Expected next state, taken from the requirements
  function automatic void model(input logic wr, input logic [1:0] a, input logic [15:0] d,
                                input logic [31:0] st, input logic [31:0] ok, input logic [31:0] fl);
    e_ab = '0;
    e_tx = '0;
    for (int i = 0; i < NMB; i++) begin
      bit sel, wp, wc, s, o, f;
      sel = wr && (int'(a[0]) == i / 16) && d[i % 16];
      wp  = sel && !a[1] && tx_cfg[i];
      wc  = sel && a[1] && (i != 0) && m_pend[i] && tx_cfg[i];
      s   = st[i] && m_pend[i] && !m_busy[i];
      o   = ok[i] && m_busy[i];
      f   = fl[i] && m_busy[i] && !ok[i];
      if (o) begin
        m_pend[i] = 0; m_canc[i] = 0; m_busy[i] = 0; e_tx[i] = 1;
      end else if (f) begin
        m_busy[i] = 0;
        if (m_canc[i] || wc) begin m_pend[i] = 0; m_canc[i] = 0; e_ab[i] = 1; end
      end else begin
        if (wc) begin
          if (m_busy[i] || s) m_canc[i] = 1;
          else begin m_pend[i] = 0; e_ab[i] = 1; end
        end else if (wp) m_pend[i] = 1;
        if (s) m_busy[i] = 1;
      end
    end
  endfunction

  task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] d,
                      input logic [31:0] st, input logic [31:0] ok, input logic [31:0] fl,
                      input string tag);
    @(negedge clk);
    cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    pe_start = st; pe_done_ok = ok; pe_done_fail = fl;
    model(wr, a, d, st, ok, fl);
    @(posedge clk);
    #1;
    cpu_wr = 1'b0; pe_start = '0; pe_done_ok = '0; pe_done_fail = '0;
    chk({tag, " R9 aback_set"}, aback_set, e_ab);
    chk({tag, " R9 txack_set"}, txack_set, e_tx);
    for (int r = 0; r < 4; r++) begin
      cpu_addr = 2'(r);
      #0.5;
      chk({tag, " R2/R3 readback"}, {16'h0, cpu_rdata}, {16'h0, exp_reg(r)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7341));
    tx_cfg = 32'hFFEF_FF7F;   // mailboxes 7 and 20 receive-only
    rst = 1'b1; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    pe_start = 0; pe_done_ok = 0; pe_done_fail = 0;
    m_pend = 0; m_canc = 0; m_busy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 aback_set after reset", aback_set, 0);
    chk("R1 txack_set after reset", txack_set, 0);
    for (int r = 0; r < 4; r++) begin
      cpu_addr = 2'(r);
      #0.5;
      chk("R1 register after reset", {16'h0, cpu_rdata}, 0);
    end

    // R2: set mailboxes 0,5,7 (7 is receive-only)
    step(1, 2'd0, 16'h00A1, 0, 0, 0, "R2 pend set");
    cpu_addr = 2'd0; #0.5;
    chk("R2 pend low value", {16'h0, cpu_rdata}, 32'h0021);
    step(1, 2'd0, 16'h0000, 0, 0, 0, "R2 zero write");

    // R3: cancel on mailbox 0 and on idle mailbox 9
    step(1, 2'd2, 16'h0001, 0, 0, 0, "R3 mb0 cancel");
    step(1, 2'd2, 16'h0200, 0, 0, 0, "R3 not pending");
    cpu_addr = 2'd0; #0.5;
    chk("R3 pending untouched", {16'h0, cpu_rdata}, 32'h0021);

    // R4: cancel waiting mailbox 5
    step(1, 2'd2, 16'h0020, 0, 0, 0, "R4 cancel idle");
    chk("R4 aback pulse mb5", aback_set, 32'h0000_0020);

    // R5 and R6: mailbox 17 in flight, cancelled, then succeeds
    step(1, 2'd1, 16'h0002, 0, 0, 0, "R2 pend hi");
    step(0, 2'd0, 16'h0, 32'h0002_0000, 0, 0, "R10 start");
    step(1, 2'd3, 16'h0002, 0, 0, 0, "R5 cancel in flight");
    cpu_addr = 2'd3; #0.5;
    chk("R5 cancel bit held", {16'h0, cpu_rdata}, 32'h0002);
    step(0, 2'd0, 16'h0, 0, 32'h0002_0000, 0, "R6 success");
    chk("R6 txack pulse mb17", txack_set, 32'h0002_0000);
    chk("R6 no aback", aback_set, 0);

    // R5 same-cycle start and cancel, then R7 failure
    step(1, 2'd0, 16'h0008, 0, 0, 0, "R2 pend mb3");
    step(1, 2'd2, 16'h0008, 32'h0000_0008, 0, 0, "R5 start with cancel");
    chk("R5 no aback on start race", aback_set, 0);
    step(0, 2'd0, 16'h0, 0, 0, 32'h0000_0008, "R7 fail cancelled");
    chk("R7 aback pulse mb3", aback_set, 32'h0000_0008);

    // R8: retry without cancel
    step(1, 2'd1, 16'h8000, 0, 0, 0, "R2 pend mb31");
    step(0, 2'd0, 16'h0, 32'h8000_0000, 0, 0, "R10 start mb31");
    step(0, 2'd0, 16'h0, 0, 0, 32'h8000_0000, "R8 fail no cancel");
    cpu_addr = 2'd1; #0.5;
    chk("R8 pending kept", {16'h0, cpu_rdata}, 32'h8000);
    step(0, 2'd0, 16'h0, 32'h8000_0000, 0, 0, "R8 restart");
    step(0, 2'd0, 16'h0, 0, 32'h8000_0000, 0, "R8 success");
    chk("R8 txack pulse mb31", txack_set, 32'h8000_0000);

    // R10: start on idle mailbox, stray completions
    step(0, 2'd0, 16'h0, 32'h0000_1000, 0, 0, "R10 start idle");
    step(0, 2'd0, 16'h0, 0, 32'h0000_1001, 0, "R10 stray success");
    chk("R10 stray ignored", txack_set, 0);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra, rb, rc, rd, okm, flm, stm;
      ra = $urandom; rb = $urandom; rc = $urandom; rd = $urandom;
      okm = m_busy & ra & rb;
      flm = m_busy & ~okm & rc & rd;
      if ($urandom_range(0, 9) == 0) okm = okm | (~m_busy & $urandom & $urandom);
      stm = $urandom & $urandom & $urandom;
      step($urandom_range(0, 9) < 4, 2'($urandom_range(0, 3)),
           16'($urandom & $urandom), stm, okm, flm, "random");
    end
    finish_run();
  end
endmodule